// File: doc/BRIEF.md
# Scheduling List Install/Split Resolver

This block sits beside the scheduling list of a dynamically scheduled wide-issue scheduler. Each cycle, every list entry presents a candidate instruction and a set of dependency flags. The dependency flags come from comparators that are outside this block. For each entry the block picks exactly one action:

- **install:** place the candidate in the long instruction of that entry.
- **split:** close the long instruction at that point.
- **move up:** advance the candidate by one entry.

The three action outputs are registered.

Whether entry k must install depends on whether entry k-1 installs, which in turn depends on entry k-2, and so on back to the head of the list. This chain is resolved like a carry. Each entry has:

- a generate term: a true or resource dependency on instructions already placed.
- a propagate term: a true or resource dependency on the candidate in the previous entry.

A log-depth parallel-prefix network combines these terms, so the decision delay grows with log2 of the list depth rather than with the depth itself.

Companion flags, meaning the flags caused by the previous entry's candidate, are qualified as follows:

- They are masked when the previous entry holds no valid candidate.
- The companion resource flag is also masked when the previous long instruction still has more than one free slot for the candidate.

Top module: `schedDecide`

## Requirements
- R1: A valid candidate in entry 0 is always installed, whatever its dependency inputs, and entry 0 is never split or moved up.
- R2: A valid candidate in entry k (k≥1) with trueDep[k] or resDep[k] set is installed.
- R3: A valid candidate in entry k≥1 whose only install cause is candTrueDep[k] or candResDep[k] is installed exactly when entry k-1 produces an install decision (chain value P(k-1) true).
- R4: Companion flags candTrueDep[k], candResDep[k] and candOutDep[k] have no effect when candValid[k-1] is 0.
- R5: candResDep[k] has no effect when multiSlot[k] is 1 (the previous long instruction still has more than one free slot).
- R6: A valid, non-installed candidate in entry k≥1 is split when outDep[k], antiDep[k] or ctlDep[k] is set, or when candOutDep[k] is set and entry k-1's chain value is true.
- R7: When both the install and split conditions hold for an entry, only doInstall is asserted.
- R8: A valid candidate that neither installs nor splits asserts doMoveUp.
- R9: For every entry, at most one of doInstall, doSplit and doMoveUp is 1; all three are 0 for an invalid entry and exactly one is 1 for a valid entry.
- R10: Outputs are registered. They reflect the inputs sampled at the previous rising edge, and a synchronous active-high rst clears all of them.
- R11: The parallel-prefix result equals the entry-by-entry ripple of P(k)=trueDep|resDep|((candTrueDep|candResDep)&P(k-1)) at list depths 4 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| candValid | input | N | Entry holds a valid candidate |
| resDep | input | N | Resource conflict with the long instruction of the previous entry (entry 0 ignored) |
| trueDep | input | N | True data dependency on placed instructions (entry 0 ignored) |
| outDep | input | N | Output dependency on placed instructions (entry 0 ignored) |
| antiDep | input | N | Anti dependency on placed instructions (entry 0 ignored) |
| ctlDep | input | N | Control dependency on placed instructions (entry 0 ignored) |
| candResDep | input | N | Resource conflict caused only by the candidate of entry k-1 |
| candTrueDep | input | N | True dependency caused only by the candidate of entry k-1 |
| candOutDep | input | N | Output dependency caused only by the candidate of entry k-1 |
| multiSlot | input | N | Previous long instruction has more than one free slot for this candidate |
| doInstall | output | N | Registered install action |
| doSplit | output | N | Registered split action |
| doMoveUp | output | N | Registered move-up action |

## Verification
The bench targets several chain corner cases. Each is listed with the error it would expose:

- **Long companion chains.** These are chains in which entry 3's install hinges on entries 2 and 1. A prefix network with a wrong span or a missing level would install or release entries far from the head.
- **Companion flags behind an invalid predecessor.** These expose ungated flags, which would install or split candidates with no real dependency.
- **The free-slot mask on the companion resource flag.** If the mask were applied to the wrong flag, true companion dependencies would be dropped.
- **Output dependencies on a non-installing predecessor.** These catch a split that wrongly ignores the chain.
- **Install-and-split collisions.** These catch two actions fired at once.

A sweep of every validity pattern against every companion-flag pattern at depth 4, plus random traffic at depth 8, compares each output against a ripple model.

// File: rtl/schedPkg.sv
package schedPkg;
  localparam int MAX_ENTRIES = 32;

  // per-entry strobes handed from the chain datapath to the action control
  typedef struct packed {
    logic live;        // candidate valid
    logic chainHit;    // prefix chain value P(k)
    logic splitCause;  // split condition, chain-qualified
  } entryStrobe_t;
endpackage

// File: rtl/schedChainPath.sv
module schedChainPath
  import schedPkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]     candValid,
  input  logic [N-1:0]     resDep,
  input  logic [N-1:0]     trueDep,
  input  logic [N-1:0]     outDep,
  input  logic [N-1:0]     antiDep,
  input  logic [N-1:0]     ctlDep,
  input  logic [N-1:0]     candResDep,
  input  logic [N-1:0]     candTrueDep,
  input  logic [N-1:0]     candOutDep,
  input  logic [N-1:0]     multiSlot,
  output entryStrobe_t [N-1:0] strb
);
  localparam int LEVELS = $clog2(N);

  logic [N-1:0] coEff;
  logic [N-1:0] genLvl  [LEVELS+1];
  logic [N-1:0] propLvl [LEVELS+1];
  logic [N-1:0] chain;

  // entry 0 dependency inputs are meaningless at the head of the list
  logic unusedHeadBits;
  assign unusedHeadBits = ^{resDep[0], trueDep[0], outDep[0], antiDep[0], ctlDep[0],
                            candResDep[0], candTrueDep[0], candOutDep[0], multiSlot[0],
                            candValid[N-1]};

  // flag conditioning: generate / propagate terms per entry
  always_comb begin
    genLvl[0]  = '0;
    propLvl[0] = '0;
    coEff      = '0;
    genLvl[0][0] = 1'b1;
    for (int k = 1; k < N; k++) begin
      genLvl[0][k]  = trueDep[k] | resDep[k];
      propLvl[0][k] = candValid[k-1] & (candTrueDep[k] | (candResDep[k] & ~multiSlot[k]));
      coEff[k]      = candValid[k-1] & candOutDep[k];
    end
  end

  // log-depth parallel-prefix AND-OR network
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int SPAN = 1 << lv;
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= SPAN) begin : g_merge
        assign genLvl[lv+1][i]  = genLvl[lv][i] | (propLvl[lv][i] & genLvl[lv][i-SPAN]);
        assign propLvl[lv+1][i] = propLvl[lv][i] & propLvl[lv][i-SPAN];
      end else begin : g_pass
        assign genLvl[lv+1][i]  = genLvl[lv][i];
        assign propLvl[lv+1][i] = propLvl[lv][i];
      end
    end
  end

  assign chain = genLvl[LEVELS];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      strb[k].live     = candValid[k];
      strb[k].chainHit = chain[k];
      if (k == 0) strb[k].splitCause = 1'b0;
      else strb[k].splitCause = outDep[k] | antiDep[k] | ctlDep[k] | (coEff[k] & chain[k-1]);
    end
  end
endmodule

// File: rtl/schedActionCtl.sv
module schedActionCtl
  import schedPkg::*;
#(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  entryStrobe_t [N-1:0] strb,
  output logic [N-1:0]         doInstall,
  output logic [N-1:0]         doSplit,
  output logic [N-1:0]         doMoveUp
);
  logic [N-1:0] nextInstall, nextSplit, nextMoveUp;

  // install outranks split; move-up is the fallback
  always_comb begin
    for (int k = 0; k < N; k++) begin
      nextInstall[k] = strb[k].live & strb[k].chainHit;
      nextSplit[k]   = strb[k].live & ~strb[k].chainHit & strb[k].splitCause;
      nextMoveUp[k]  = strb[k].live & ~strb[k].chainHit & ~strb[k].splitCause;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doInstall <= '0;
      doSplit   <= '0;
      doMoveUp  <= '0;
    end else begin
      doInstall <= nextInstall;
      doSplit   <= nextSplit;
      doMoveUp  <= nextMoveUp;
    end
  end
endmodule

// File: rtl/schedDecide.sv
module schedDecide
  import schedPkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] candValid,
  input  logic [N-1:0] resDep,
  input  logic [N-1:0] trueDep,
  input  logic [N-1:0] outDep,
  input  logic [N-1:0] antiDep,
  input  logic [N-1:0] ctlDep,
  input  logic [N-1:0] candResDep,
  input  logic [N-1:0] candTrueDep,
  input  logic [N-1:0] candOutDep,
  input  logic [N-1:0] multiSlot,
  output logic [N-1:0] doInstall,
  output logic [N-1:0] doSplit,
  output logic [N-1:0] doMoveUp
);
  entryStrobe_t [N-1:0] strb;

  initial begin
    if (N < 2 || N > MAX_ENTRIES) $error("schedDecide: N out of range");
  end

  schedChainPath #(.N(N)) chainPath (
    .candValid(candValid), .resDep(resDep), .trueDep(trueDep), .outDep(outDep),
    .antiDep(antiDep), .ctlDep(ctlDep), .candResDep(candResDep),
    .candTrueDep(candTrueDep), .candOutDep(candOutDep), .multiSlot(multiSlot),
    .strb(strb)
  );

  schedActionCtl #(.N(N)) actionCtl (
    .clk(clk), .rst(rst), .strb(strb),
    .doInstall(doInstall), .doSplit(doSplit), .doMoveUp(doMoveUp)
  );
endmodule

// File: rtl/schedDecideChk.sv
module schedDecideChk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] candValid,
  input logic [N-1:0] resDep,
  input logic [N-1:0] trueDep,
  input logic [N-1:0] outDep,
  input logic [N-1:0] antiDep,
  input logic [N-1:0] ctlDep,
  input logic [N-1:0] doInstall,
  input logic [N-1:0] doSplit,
  input logic [N-1:0] doMoveUp
);
  // R1
  head_install_chk: assert property (@(posedge clk) disable iff (rst)
    candValid[0] |=> doInstall[0]);

  // R1
  head_no_other_chk: assert property (@(posedge clk) disable iff (rst)
    !(doSplit[0] || doMoveUp[0]));

  // R2
  dep_install_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(candValid & (trueDep | resDep)) & ~doInstall) == '0));

  // R6
  dep_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(candValid & (outDep | antiDep | ctlDep)) & doMoveUp) == '0));

  // R9
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    ((doInstall & doSplit) | (doInstall & doMoveUp) | (doSplit & doMoveUp)) == '0);

  // R9
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((doInstall | doSplit | doMoveUp) == $past(candValid)));
endmodule

bind schedDecide schedDecideChk #(.N(N)) decideChk (
  .clk(clk), .rst(rst), .candValid(candValid), .resDep(resDep), .trueDep(trueDep),
  .outDep(outDep), .antiDep(antiDep), .ctlDep(ctlDep),
  .doInstall(doInstall), .doSplit(doSplit), .doMoveUp(doMoveUp)
);

// File: tb/schedDecide_test.sv
module schedDecide_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0] v, r, t, o, a, c, cr, ct, co, ms;
  logic [3:0] inst4, split4, move4;
  logic [7:0] inst8, split8, move8;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  schedDecide #(.N(4)) uut (
    .clk(clk), .rst(rst), .candValid(v[3:0]), .resDep(r[3:0]), .trueDep(t[3:0]),
    .outDep(o[3:0]), .antiDep(a[3:0]), .ctlDep(c[3:0]), .candResDep(cr[3:0]),
    .candTrueDep(ct[3:0]), .candOutDep(co[3:0]), .multiSlot(ms[3:0]),
    .doInstall(inst4), .doSplit(split4), .doMoveUp(move4)
  );

  schedDecide #(.N(8)) uut8 (
    .clk(clk), .rst(rst), .candValid(v), .resDep(r), .trueDep(t),
    .outDep(o), .antiDep(a), .ctlDep(c), .candResDep(cr),
    .candTrueDep(ct), .candOutDep(co), .multiSlot(ms),
    .doInstall(inst8), .doSplit(split8), .doMoveUp(move8)
  );

  // ripple reference: returns {move, split, install}, 8 bits each
  function automatic logic [23:0] refModel(int n);
    logic [7:0] ei = '0, es = '0, em = '0;
    logic pPrev = 1'b0, p, sc;
    for (int k = 0; k < n; k++) begin
      if (k == 0) begin
        p = 1'b1; sc = 1'b0;
      end else begin
        p  = t[k] | r[k] | (((ct[k] & v[k-1]) | (cr[k] & v[k-1] & ~ms[k])) & pPrev);
        sc = o[k] | a[k] | c[k] | (co[k] & v[k-1] & pPrev);
      end
      ei[k] = v[k] & p;
      es[k] = v[k] & ~p & sc;
      em[k] = v[k] & ~p & ~sc;
      pPrev = p;
    end
    return {em, es, ei};
  endfunction

  task automatic clearIn();
    {v, r, t, o, a, c, cr, ct, co, ms} = '0;
  endtask

  // inputs are set at a falling edge; one rising edge registers them
  task automatic apply(string tag);
    logic [23:0] e4, e8;
    e4 = refModel(4);
    e8 = refModel(8);
    @(negedge clk);
    checks++;
    if ({move4, split4, inst4} !== {e4[19:16], e4[11:8], e4[3:0]}) begin
      errors++;
      $display("FAIL %s N=4 got mv/sp/in=%b/%b/%b expected %b/%b/%b", tag,
               move4, split4, inst4, e4[19:16], e4[11:8], e4[3:0]);
    end
    checks++;
    if ({move8, split8, inst8} !== e8) begin
      errors++;
      $display("FAIL %s N=8 got mv/sp/in=%b/%b/%b expected %b/%b/%b", tag,
               move8, split8, inst8, e8[23:16], e8[15:8], e8[7:0]);
    end
  endtask

  task automatic expectBits(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    clearIn();
    v = 8'hFF; t = 8'h0F;
    repeat (3) @(negedge clk);
    checks++;
    if ({inst4, split4, move4, inst8, split8, move8} !== '0) begin
      errors++;
      $display("FAIL R10 reset got %h expected 0", {inst4, split4, move4, inst8, split8, move8});
    end
    rst = 1'b0;

    // R1: head installs even with every dependency flag set on it
    clearIn(); v = 8'h01; {r[0], t[0], o[0], a[0], c[0], cr[0], ct[0], co[0]} = '1;
    apply("R1");
    expectBits("R1 head install", inst4, 4'b0001);
    // R2
    clearIn(); v = 8'h0F; t[2] = 1'b1; r[3] = 1'b1;
    apply("R2");
    expectBits("R2 install", inst4, 4'b1101);
    // R3: chain through installing predecessor, then broken chain
    clearIn(); v = 8'h0F; ct[1] = 1'b1; cr[2] = 1'b1; ct[3] = 1'b1;
    apply("R3 long chain");
    expectBits("R3 chain install", inst4, 4'b1111);
    clearIn(); v = 8'h0F; ct[2] = 1'b1;
    apply("R3 broken chain");
    expectBits("R3 move up", move4, 4'b1110);
    // R4: companion flags behind an invalid entry
    clearIn(); v = 8'h0A; ct[1] = 1'b1; co[1] = 1'b1; cr[1] = 1'b1;
    apply("R4");
    expectBits("R4 no effect", move4, 4'b1010);
    // R5: companion resource flag masked by free slot
    clearIn(); v = 8'h03; cr[1] = 1'b1; ms[1] = 1'b1;
    apply("R5 masked");
    expectBits("R5 masked move", move4, 4'b0010);
    ms[1] = 1'b0;
    apply("R5 unmasked");
    expectBits("R5 unmasked install", inst4, 4'b0011);
    // R6: chain-qualified output dependency, and plain anti dependency
    clearIn(); v = 8'h07; co[1] = 1'b1; co[2] = 1'b1; a[2] = 1'b0;
    apply("R6 co");
    expectBits("R6 split", split4, 4'b0010);
    clearIn(); v = 8'h07; a[2] = 1'b1; c[1] = 1'b1;
    apply("R6 anti/ctl");
    expectBits("R6 split plain", split4, 4'b0110);
    // R7
    clearIn(); v = 8'h03; t[1] = 1'b1; o[1] = 1'b1;
    apply("R7");
    expectBits("R7 install only", split4, 4'b0000);
    // R8 and R9
    clearIn(); v = 8'h05;
    apply("R8 R9");
    expectBits("R8 move", move4, 4'b0100);
    expectBits("R9 invalid idle", (inst4 | split4 | move4) & 4'b1010, 4'b0000);

    // R11: sweep valid x companion pattern x free-slot mask at depth 4
    for (int vv = 0; vv < 16; vv++)
      for (int code = 0; code < 64; code++)
        for (int msk = 0; msk < 2; msk++) begin
          clearIn();
          v = 8'(vv);
          for (int k = 1; k < 4; k++) begin
            int sel = (code >> (2 * (k - 1))) & 3;
            ct[k] = (sel == 1);
            cr[k] = (sel == 2);
            co[k] = (sel == 3);
            ms[k] = msk[0] ^ k[0];
          end
          t[1] = code[0] & vv[3];
          o[3] = code[5] & msk[0];
          apply("R11 sweep");
        end

    // R11: random traffic at depth 8
    for (int n = 0; n < 3000; n++) begin
      v  = 8'($urandom | $urandom);
      r  = 8'($urandom & $urandom & $urandom);
      t  = 8'($urandom & $urandom & $urandom);
      o  = 8'($urandom & $urandom & $urandom);
      a  = 8'($urandom & $urandom & $urandom & $urandom);
      c  = 8'($urandom & $urandom & $urandom & $urandom);
      cr = 8'($urandom);
      ct = 8'($urandom);
      co = 8'($urandom & $urandom);
      ms = 8'($urandom);
      apply("R11 random");
    end

    // R10: synchronous reset clears outputs mid-run
    clearIn(); v = 8'hFF;
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if ({inst4, inst8} !== '0) begin
      errors++;
      $display("FAIL R10 sync reset got %h expected 0", {inst4, inst8});
    end
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule